// File: doc/BRIEF.md
# Manchester Sync Stream Serializer

This block drives a single Manchester-coded line used to keep several acquisition crates in lockstep. When nothing is pending, the line carries an unbroken run of one bits. The receiver recovers its clock from this run. Each frame boundary strobe (ARZ) marks its place in the stream. If the strobe is a plain frame boundary, it marks it with a single zero bit. If the strobe is also selected as a data-valid frame, it sends a 40-bit sync word, and the first bit of that word is the boundary zero. The word carries a mode flag, an error flag and a 32-bit frame sequence number.

The clock is the half-bit clock, so every bit lasts two cycles. A request is captured together with a snapshot of the word on the edge that accepts it. Transmission begins at the next bit boundary. The upstream sequencer sees `busy` while a request is still waiting to have its last bit launched. An output-enable input silences the line completely.

Top module: `sync_stream_tx`

## Requirements
- R1: With no request pending, every bit period on `lineOut` is a logic one.
- R2: Each bit occupies two clock cycles. A one is sent as high then low, and a zero as low then high. The first enabled edge after reset or after enabling starts a bit, and so does every second edge after it.
- R3: A strobe with `dvSel` low produces exactly one zero bit, and the bits around it are ones.
- R4: A strobe with `dvSel` high produces a 40-bit word sent from bit 0 upward. Bits 0 and 1 are 0, and bits 2, 5, 6 and 7 are 1.
- R5: Word bit 3 equals `freeRun` and word bit 4 equals `dvErr`.
- R6: Word bits 8 to 39 carry `frameNum`, with its most significant bit at word bit 8 and its least significant bit at word bit 39.
- R7: Word contents are taken on the accepting edge. Changing `frameNum`, `freeRun` or `dvErr` after that edge does not alter the word in flight.
- R8: Take a strobe accepted at clock edge E. Its first bit starts at the first bit boundary strictly after E.
- R9: `busy` is high from the accepting edge until the edge that launches the request's final bit. A strobe seen on any edge where `busy` is high is ignored. A strobe on the edge right after the final launch is accepted.
- R10: While `outEn` is low, `lineOut` and `busy` are 0, strobes are ignored and any unsent request is dropped. On re-enable, the stream restarts with idle ones.
- R11: During reset, `lineOut` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit clock (two cycles per bit) |
| rstN | input | 1 | Active-low synchronous reset |
| outEn | input | 1 | Line enable; low silences the line |
| arzStb | input | 1 | Frame-boundary request strobe |
| dvSel | input | 1 | Request carries the full sync word |
| freeRun | input | 1 | Mode flag placed in word bit 3 |
| dvErr | input | 1 | Error flag placed in word bit 4 |
| frameNum | input | FRAME_W | Frame sequence number for the word |
| lineOut | output | 1 | Manchester-coded line |
| busy | output | 1 | Request accepted but not fully launched |

## Verification
A new strobe and the launch of the previous request's final bit can fall on the same clock edge. The bench waits until that exact edge, strobes there, and expects the strobe to leave no trace in the decoded stream. It then strobes again on the very next edge and expects that request to be placed directly behind the previous one. Separately, every request is issued both on a bit boundary and one cycle off it. The decoded bit position of each word is then compared with the position the start-at-next-boundary rule predicts.

// File: rtl/sst_pkg.sv
package sst_pkg;
  // Fixed header ahead of the frame number in a sync word
  localparam int HDR_BITS = 8;

  typedef struct packed {
    logic idle;        // line disabled this cycle
    logic firstHalf;   // edge starts a new bit
    logic secondHalf;  // edge starts the inverted half
    logic shift;       // launch next word bit
    logic load;        // capture a new request
    logic loadDv;      // captured request is a full word
  } sstCtl_t;
endpackage

// File: rtl/sst_ctrl.sv
module sst_ctrl
  import sst_pkg::*;
#(
  parameter int FRAME_W = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    outEn,
  input  logic    arzStb,
  input  logic    dvSel,
  output sstCtl_t ctl,
  output logic    busy
);
  localparam int WORD_LEN = HDR_BITS + FRAME_W;
  localparam int CNT_W = $clog2(WORD_LEN + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_LEN);
  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

  logic             phase;
  logic [CNT_W-1:0] bitsLeft;

  always_comb begin
    ctl.idle       = !outEn;
    ctl.firstHalf  = outEn && !phase;
    ctl.secondHalf = outEn && phase;
    ctl.shift      = outEn && !phase && (bitsLeft != '0);
    ctl.load       = outEn && arzStb && (bitsLeft == '0);
    ctl.loadDv     = dvSel;
  end

  assign busy = (bitsLeft != '0);

  always_ff @(posedge clk) begin
    if (!rstN || !outEn) begin
      phase    <= 1'b0;
      bitsLeft <= '0;
    end else begin
      phase <= !phase;
      if (ctl.load)
        bitsLeft <= dvSel ? FULL_CNT : ONE_CNT;
      else if (ctl.shift)
        bitsLeft <= bitsLeft - ONE_CNT;
    end
  end

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitsLeft <= FULL_CNT);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && arzStb && outEn) |=> (bitsLeft <= $past(bitsLeft)));

  // R2
  single_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shift |=> !ctl.shift);
endmodule

// File: rtl/sst_dpath.sv
module sst_dpath
  import sst_pkg::*;
#(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  sstCtl_t            ctl,
  input  logic               freeRun,
  input  logic               dvErr,
  input  logic [FRAME_W-1:0] frameNum,
  output logic               lineOut
);
  localparam int WORD_LEN = HDR_BITS + FRAME_W;
  localparam logic [WORD_LEN-1:0] ARZ_ONLY = {{(WORD_LEN-1){1'b1}}, 1'b0};

  logic [WORD_LEN-1:0] word;
  logic [WORD_LEN-1:0] shreg;
  logic                curBit;
  logic                nextBit;

  // header: [1:0] zero, [2] one, [3] mode, [4] error, [7:5] ones
  assign word[HDR_BITS-1:0] = {3'b111, dvErr, freeRun, 1'b1, 2'b00};

  // frame number reversed so its MSB leaves first
  for (genvar gi = 0; gi < FRAME_W; gi++) begin : g_rev
    assign word[HDR_BITS+gi] = frameNum[FRAME_W-1-gi];
  end

  assign nextBit = ctl.shift ? shreg[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN || ctl.idle)
      shreg <= '1;
    else if (ctl.load)
      shreg <= ctl.loadDv ? word : ARZ_ONLY;
    else if (ctl.shift)
      shreg <= {1'b1, shreg[WORD_LEN-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.idle) begin
      lineOut <= 1'b0;
      curBit  <= 1'b1;
    end else if (ctl.firstHalf) begin
      lineOut <= nextBit;
      curBit  <= nextBit;
    end else if (ctl.secondHalf) begin
      lineOut <= !curBit;
    end
  end

  // R2
  manch_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.secondHalf |=> (lineOut != $past(lineOut)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.idle |=> !lineOut);

  // R4
  lead_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> !shreg[0]);
endmodule

// File: rtl/sync_stream_tx.sv
module sync_stream_tx
  import sst_pkg::*;
#(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               outEn,
  input  logic               arzStb,
  input  logic               dvSel,
  input  logic               freeRun,
  input  logic               dvErr,
  input  logic [FRAME_W-1:0] frameNum,
  output logic               lineOut,
  output logic               busy
);
  sstCtl_t ctl;

  sst_ctrl #(.FRAME_W(FRAME_W)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .outEn  (outEn),
    .arzStb (arzStb),
    .dvSel  (dvSel),
    .ctl    (ctl),
    .busy   (busy)
  );

  sst_dpath #(.FRAME_W(FRAME_W)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .freeRun  (freeRun),
    .dvErr    (dvErr),
    .frameNum (frameNum),
    .lineOut  (lineOut)
  );

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!lineOut && !busy));
endmodule

// File: tb/sync_stream_tx_test.sv
module sync_stream_tx_test;
  localparam int NB = 8192;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        outEn = 1'b1;
  logic        arzStb = 1'b0;
  logic        dvSel = 1'b0;
  logic        freeRun = 1'b0;
  logic        dvErr = 1'b0;
  logic [31:0] frameNum = '0;
  logic        lineOut;
  logic        busy;

  always #10 clk = ~clk;

  sync_stream_tx #(.FRAME_W(32)) uut (
    .clk(clk), .rstN(rstN), .outEn(outEn), .arzStb(arzStb), .dvSel(dvSel),
    .freeRun(freeRun), .dvErr(dvErr), .frameNum(frameNum),
    .lineOut(lineOut), .busy(busy)
  );

  int    checks = 0;
  int    fails = 0;
  logic  expBit[NB];
  string expTag[NB];
  int    h = 0;
  bit    monOn = 1'b0;
  logic  firstS;
  int    lastIdx = -1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Decoder: one sample per edge, a bit per sample pair
  always @(posedge clk) begin
    int idx;
    #5;
    if (monOn) begin
      h++;
      if (h % 2 == 1) firstS = lineOut;
      else begin
        idx = h / 2 - 1;
        // R2 halves must differ
        chk(firstS !== lineOut, "R2", $sformatf("halves of bit %0d", idx),
            {62'd0, firstS, lineOut}, {62'd0, firstS, !firstS});
        if (idx < NB)
          chk(firstS === expBit[idx], expTag[idx], $sformatf("stream bit %0d", idx),
              {63'd0, firstS}, {63'd0, expBit[idx]});
      end
    end
  end

  // Issue one strobe at a negedge and predict its placement (R8, R9)
  task automatic req(input bit dv, input bit fr, input bit err,
                     input logic [31:0] fn, input string frameTag);
    int  hh;
    bit  acc;
    int  st;
    hh = h;
    acc = (hh >= 2 * lastIdx + 1);
    arzStb = 1'b1; dvSel = dv; freeRun = fr; dvErr = err; frameNum = fn;
    @(negedge clk);
    arzStb = 1'b0;
    if (acc) begin
      st = hh / 2 + 1;
      chk(busy === 1'b1, "R9", "busy after accept", {63'd0, busy}, 64'd1);
      if (!dv) begin
        expBit[st] = 1'b0; expTag[st] = "R3";
        lastIdx = st;
      end else begin
        expBit[st] = 1'b0;     expTag[st] = "R8";
        expBit[st+1] = 1'b0;   expTag[st+1] = "R4";
        expBit[st+2] = 1'b1;   expTag[st+2] = "R4";
        expBit[st+3] = fr;     expTag[st+3] = "R5";
        expBit[st+4] = err;    expTag[st+4] = "R5";
        for (int k = 5; k < 8; k++) begin
          expBit[st+k] = 1'b1; expTag[st+k] = "R4";
        end
        for (int k = 0; k < 32; k++) begin
          expBit[st+8+k] = fn[31-k]; expTag[st+8+k] = frameTag;
        end
        lastIdx = st + 39;
      end
    end
  endtask

  task automatic waitIdle();
    while (h < 2 * lastIdx + 8) @(negedge clk);
    chk(busy === 1'b0, "R9", "busy after final launch", {63'd0, busy}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] fn;
    for (int i = 0; i < NB; i++) begin
      expBit[i] = 1'b1; expTag[i] = "R1";
    end
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(lineOut === 1'b0, "R11", "line in reset", {63'd0, lineOut}, 64'd0);
    chk(busy === 1'b0, "R11", "busy in reset", {63'd0, busy}, 64'd0);
    rstN = 1'b1;
    monOn = 1'b1;
    repeat (20) @(negedge clk);   // R1 idle ones

    // Sweep flags, frame patterns and boundary skew (R4 R5 R6 R8)
    for (int fr = 0; fr < 2; fr++)
      for (int er = 0; er < 2; er++)
        for (int k = 0; k < 5; k++)
          for (int sk = 0; sk < 2; sk++) begin
            case (k)
              0: fn = 32'h0000_0000;
              1: fn = 32'hFFFF_FFFF;
              2: fn = 32'h8000_0001;
              3: fn = 32'hA5C3_0F96;
              default: fn = 32'h0001_0003 << (fr * 4 + er * 2 + sk);
            endcase
            repeat (sk) @(negedge clk);
            req(1'b1, fr[0], er[0], fn, "R6");
            waitIdle();
          end

    // Plain boundary zero on and off a bit boundary (R3)
    for (int sk = 0; sk < 2; sk++) begin
      repeat (sk) @(negedge clk);
      req(1'b0, 1'b0, 1'b0, 32'h0, "R6");
      waitIdle();
    end

    // Back-to-back zeros: strobe on the first free edge (R9)
    req(1'b0, 1'b0, 1'b0, 32'h0, "R6");
    while (h < 2 * lastIdx + 1) @(negedge clk);
    req(1'b0, 1'b0, 1'b0, 32'h0, "R6");
    waitIdle();

    // Collision: strobe on the final-launch edge is ignored, next accepted (R9)
    req(1'b1, 1'b1, 1'b0, 32'h1357_9BDF, "R6");
    repeat (10) @(negedge clk);
    req(1'b0, 1'b0, 1'b0, 32'h0, "R6");          // mid-word, ignored
    while (h < 2 * lastIdx) @(negedge clk);
    req(1'b1, 1'b0, 1'b1, 32'hDEAD_0000, "R6");  // on launch edge, ignored
    req(1'b1, 1'b0, 1'b1, 32'h0F0F_F0F0, "R6");  // next edge, accepted
    waitIdle();

    // Inputs change while the word is in flight (R7)
    req(1'b1, 1'b1, 1'b1, 32'hC001_7E55, "R7");
    for (int i = 0; i < 30; i++) begin
      frameNum = 32'h1111_1111 * i; freeRun = i[0]; dvErr = i[1];
      @(negedge clk);
    end
    waitIdle();

    // Disable: line quiet, strobe dropped, clean restart (R10)
    monOn = 1'b0;
    outEn = 1'b0;
    @(negedge clk);
    arzStb = 1'b1; dvSel = 1'b1;
    @(negedge clk);
    arzStb = 1'b0;
    chk(lineOut === 1'b0, "R10", "line while disabled", {63'd0, lineOut}, 64'd0);
    chk(busy === 1'b0, "R10", "busy while disabled", {63'd0, busy}, 64'd0);
    repeat (2) @(negedge clk);
    chk(lineOut === 1'b0, "R10", "line still quiet", {63'd0, lineOut}, 64'd0);
    outEn = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(lineOut === ((i % 2) == 0), "R10", $sformatf("restart half %0d", i),
          {63'd0, lineOut}, {63'd0, ((i % 2) == 0)});
    end
    chk(busy === 1'b0, "R10", "no request after restart", {63'd0, busy}, 64'd0);
    finishRun();
  end
endmodule